// File: doc/BRIEF.md
# Load/Store Sub-Word Data Aligner

This block sits between a 32-bit register file and the external data bus and handles the size and alignment of each memory access. On a load it takes the bus word and selects the byte or half-word named by the size code and the two low address bits. It moves that object to the low end of the result and fills the bits above it with zeros or with copies of the object's top bit, as the sign-extend flag asks.

On a store it copies the sub-word value into every lane of the write data. External byte-enable logic then picks the lane to write. The block also checks the alignment of every access. It raises a trap request for a misaligned access when the processor status enables such traps and the access targets instruction or data memory. A trapped access is suppressed in the same cycle as the request.

Each accepted request produces one registered result one clock later. Lanes are numbered big-endian.

Top module: `ldst_aligner`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every output is zero.
- R2: `rsp_valid` is high exactly one clock after a cycle with `req_valid` high, and low otherwise. All other outputs are zero in cycles where `rsp_valid` is low.
- R3: Size code 1 means a byte and size code 2 means a half-word. Every other code (0, 3 to 7) is handled as a 32-bit word. A committed word load returns the bus word unchanged.
- R4: A byte or half-word load places the selected object at bit 0 of `ld_result`. Lanes are big-endian: byte offset 0 selects bits 31:24 and offset 3 selects bits 7:0. For a half-word, address bit 1 picks the half: 0 selects bits 31:16 and 1 selects bits 15:0.
- R5: With `req_sext` high, the bits of `ld_result` above a loaded byte or half-word are copies of that object's most significant bit.
- R6: With `req_sext` low, the bits of `ld_result` above a loaded byte or half-word are zero.
- R7: A byte store drives its byte (bits 7:0 of `st_data`) on all four lanes of `wr_data`. A half-word store drives bits 15:0 on both halves. A word store drives `st_data` unchanged. `req_sext` has no effect on stores.
- R8: A word access is misaligned when either low address bit is set. A half-word access is misaligned when address bit 0 is set. A byte access is never misaligned.
- R9: A misaligned access raises `trap_req` only when `ua_enable` is high.
- R10: Address spaces are coded 0 = instruction memory, 1 = data memory, 2 = I/O and 3 = coprocessor. Only spaces 0 and 1 are alignment-checked; accesses to spaces 2 and 3 never raise `trap_req`.
- R11: When `trap_req` is high, `ld_commit` and `wr_drive` are low and `ld_result` and `wr_data` are zero in that same cycle. Without a trap, `ld_commit` is high for loads and `wr_drive` is high for stores.
- R12: Without a trap, a misaligned half-word load or store ignores address bit 0, and a misaligned word access is handled as if it were aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Object size code |
| req_addr_lo | input | 2 | Low address bits of the access |
| req_sext | input | 1 | Sign-extend loaded sub-word |
| req_space | input | 2 | Address space code |
| ua_enable | input | 1 | Unaligned-access trap enable from processor status |
| bus_rdata | input | 32 | Word read from the external bus |
| st_data | input | 32 | Register value to store |
| rsp_valid | output | 1 | Result of last cycle's request |
| ld_result | output | 32 | Aligned and extended load value |
| ld_commit | output | 1 | Load result may be written back |
| wr_data | output | 32 | Replicated store data |
| wr_drive | output | 1 | Write data is to be driven on the bus |
| trap_req | output | 1 | Unaligned-access trap request |

## Verification
The bench walks every byte offset and both half-word offsets with lane values chosen so that a reversed lane order, or a half select taken from the wrong address bit, shows up as a wrong value. It loads sub-words whose top bit is set and also clear, under both states of the extend flag, to catch filling with the wrong bit or from the wrong width. Misaligned accesses are sent to all four spaces, with trap enable both high and low, so the bench sees a trap in I/O space, a trap on a byte, or a trapped access that still drives data or commits. Stores with the extend flag set and values whose high bits are nonzero catch replication of the wrong bits and any influence of the flag on writes.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZC_WORD = 2'd0,
    SZC_BYTE = 2'd1,
    SZC_HALF = 2'd2
  } size_class_e;

  typedef enum logic [1:0] {
    SPC_INSTR = 2'd0,
    SPC_DATA  = 2'd1,
    SPC_IO    = 2'd2,
    SPC_COPRO = 2'd3
  } space_e;

  localparam int SIZE_CODE_W = 3;
  localparam int LANE_W      = 8;

  // Codes outside byte and half-word fall back to whole-word handling.
  function automatic size_class_e classify_size(input logic [SIZE_CODE_W-1:0] code);
    case (code)
      3'd1:    return SZC_BYTE;
      3'd2:    return SZC_HALF;
      default: return SZC_WORD;
    endcase
  endfunction

  function automatic logic space_checked(input logic [1:0] spc);
    return (spc == SPC_INSTR) || (spc == SPC_DATA);
  endfunction

endpackage

// File: rtl/ldst_align_check.sv
module ldst_align_check
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  size_class_e       szc,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [1:0]        space,
  input  logic              ua_en,
  output logic              misaligned,
  output logic              trap
);

  always_comb begin
    unique case (szc)
      SZC_BYTE: misaligned = 1'b0;
      SZC_HALF: misaligned = addr_lo[0];
      default:  misaligned = |addr_lo;
    endcase
    trap = misaligned && ua_en && space_checked(space);
  end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 bus_word,
  input  size_class_e                       szc,
  input  logic [$clog2(DATA_W/LANE_W)-1:0]  addr_lo,
  input  logic                              sext,
  output logic [DATA_W-1:0]                 result
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int ADDR_W = $clog2(LANES);
  localparam int HALF_W = 2 * LANE_W;
  localparam int HALVES = LANES / 2;

  logic [LANE_W-1:0] lane_v [LANES];
  logic [HALF_W-1:0] half_v [HALVES];

  // Big-endian numbering: index 0 is the most significant slice.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = bus_word[DATA_W-1-g*LANE_W -: LANE_W];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_v[h] = bus_word[DATA_W-1-h*HALF_W -: HALF_W];
  end

  logic [LANE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;

  always_comb begin
    sel_byte = lane_v[addr_lo];
    sel_half = half_v[addr_lo[ADDR_W-1:1]];
    unique case (szc)
      SZC_BYTE: result = {{(DATA_W-LANE_W){sext & sel_byte[LANE_W-1]}}, sel_byte};
      SZC_HALF: result = {{(DATA_W-HALF_W){sext & sel_half[HALF_W-1]}}, sel_half};
      default:  result = bus_word;
    endcase
  end

endmodule

// File: rtl/ldst_store_replicate.sv
module ldst_store_replicate
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  size_class_e       szc,
  output logic [DATA_W-1:0] wdata
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int HALF_W = 2 * LANE_W;
  localparam int HALVES = LANES / 2;

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  for (genvar g = 0; g < LANES; g++) begin : g_brep
    assign byte_rep[g*LANE_W +: LANE_W] = src[LANE_W-1:0];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_hrep
    assign half_rep[h*HALF_W +: HALF_W] = src[HALF_W-1:0];
  end

  always_comb begin
    unique case (szc)
      SZC_BYTE: wdata = byte_rep;
      SZC_HALF: wdata = half_rep;
      default:  wdata = src;
    endcase
  end

endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_store,
  input  logic [SIZE_CODE_W-1:0] req_size,
  input  logic [1:0]             req_addr_lo,
  input  logic                   req_sext,
  input  logic [1:0]             req_space,
  input  logic                   ua_enable,
  input  logic [DATA_W-1:0]      bus_rdata,
  input  logic [DATA_W-1:0]      st_data,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      ld_result,
  output logic                   ld_commit,
  output logic [DATA_W-1:0]      wr_data,
  output logic                   wr_drive,
  output logic                   trap_req
);

  localparam int LANES  = DATA_W / LANE_W;
  localparam int ADDR_W = $clog2(LANES);

  size_class_e       szc;
  logic [ADDR_W-1:0] addr_lo;
  logic              misaligned;
  logic              trap_now;
  logic [DATA_W-1:0] load_val;
  logic [DATA_W-1:0] store_val;

  assign szc     = classify_size(req_size);
  assign addr_lo = ADDR_W'(req_addr_lo);

  ldst_align_check #(.ADDR_W(ADDR_W)) u_chk_align (
    .szc        (szc),
    .addr_lo    (addr_lo),
    .space      (req_space),
    .ua_en      (ua_enable),
    .misaligned (misaligned),
    .trap       (trap_now)
  );

  ldst_load_extract #(.DATA_W(DATA_W)) u_load (
    .bus_word (bus_rdata),
    .szc      (szc),
    .addr_lo  (addr_lo),
    .sext     (req_sext),
    .result   (load_val)
  );

  ldst_store_replicate #(.DATA_W(DATA_W)) u_store (
    .src   (st_data),
    .szc   (szc),
    .wdata (store_val)
  );

  logic go_load, go_store, go_trap;
  assign go_trap  = req_valid && trap_now;
  assign go_load  = req_valid && !req_store && !trap_now;
  assign go_store = req_valid &&  req_store && !trap_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      trap_req  <= 1'b0;
      ld_commit <= 1'b0;
      wr_drive  <= 1'b0;
      ld_result <= '0;
      wr_data   <= '0;
    end else begin
      rsp_valid <= req_valid;
      trap_req  <= go_trap;
      ld_commit <= go_load;
      wr_drive  <= go_store;
      ld_result <= go_load  ? load_val  : '0;
      wr_data   <= go_store ? store_val : '0;
    end
  end

endmodule

// File: rtl/ldst_aligner_chk.sv
module ldst_aligner_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_store,
  input logic [2:0]        req_size,
  input logic [1:0]        req_addr_lo,
  input logic              req_sext,
  input logic [1:0]        req_space,
  input logic              ua_enable,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] st_data,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] ld_result,
  input logic              ld_commit,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_drive,
  input logic              trap_req
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_BYTE_NEVER_TRAPS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 3'd1) |=> !trap_req); // R8

  AST_TRAP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ua_enable) |=> !trap_req); // R9

  AST_NO_TRAP_IO_COPRO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_space[1]) |=> !trap_req); // R10

  AST_TRAP_SUPPRESSES: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (!ld_commit && !wr_drive && wr_data == '0 && ld_result == '0)); // R11

  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store && req_size == 3'd1 && !req_sext) |=> (ld_result[DATA_W-1:8] == '0)); // R6

  AST_BYTE_STORE_REPL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && req_size == 3'd1) |=>
      (wr_data[31:24] == wr_data[7:0] && wr_data[23:16] == wr_data[7:0] && wr_data[15:8] == wr_data[7:0])); // R7

endmodule

bind ldst_aligner ldst_aligner_chk #(.DATA_W(DATA_W)) u_ldst_chk (.*);

// File: tb/tb_ldst_aligner.sv
module tb_ldst_aligner;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, req_sext, ua_enable;
  logic [2:0]  req_size;
  logic [1:0]  req_addr_lo, req_space;
  logic [31:0] bus_rdata, st_data;
  logic        rsp_valid, ld_commit, wr_drive, trap_req;
  logic [31:0] ld_result, wr_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  typedef struct {
    logic        v, t, c, d;
    logic [31:0] res, wd;
    string       tag;
  } exp_t;

  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_aligner dut (.*);

  function automatic exp_t model(bit v, bit st, bit [2:0] sz, bit [1:0] a, bit sx,
                                 bit [1:0] sp, bit ua, bit [31:0] bus, bit [31:0] sd, string tag);
    exp_t e;
    bit is_b = (sz == 1), is_h = (sz == 2);
    bit mis;
    bit [31:0] lv, sv;
    int sh;
    mis = is_b ? 1'b0 : (is_h ? a[0] : (a != 0));
    if (is_b) begin
      sh = 8 * (3 - a);
      lv = (bus >> sh) & 32'hFF;
      if (sx && lv[7]) lv = lv | 32'hFFFF_FF00;
      sv = {4{sd[7:0]}};
    end else if (is_h) begin
      sh = a[1] ? 0 : 16;
      lv = (bus >> sh) & 32'hFFFF;
      if (sx && lv[15]) lv = lv | 32'hFFFF_0000;
      sv = {2{sd[15:0]}};
    end else begin
      lv = bus;
      sv = sd;
    end
    e.v   = v;
    e.t   = v && mis && ua && (sp < 2);
    e.c   = v && !st && !e.t;
    e.d   = v && st && !e.t;
    e.res = e.c ? lv : 32'h0;
    e.wd  = e.d ? sv : 32'h0;
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    exp_t e;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    chk("R2",  "rsp_valid", {31'b0, rsp_valid}, {31'b0, e.v});
    chk(e.tag, "trap_req",  {31'b0, trap_req},  {31'b0, e.t});
    chk("R11", "ld_commit", {31'b0, ld_commit}, {31'b0, e.c});
    chk("R11", "wr_drive",  {31'b0, wr_drive},  {31'b0, e.d});
    chk(e.tag, "ld_result", ld_result, e.res);
    chk(e.tag, "wr_data",   wr_data,   e.wd);
  endtask

  // One clock: check last cycle's result, then apply a new request.
  task automatic step(bit v, bit st, bit [2:0] sz, bit [1:0] a, bit sx,
                      bit [1:0] sp, bit ua, bit [31:0] bus, bit [31:0] sd, string tag);
    @(negedge clk);
    compare_outputs();
    req_valid = v; req_store = st; req_size = sz; req_addr_lo = a; req_sext = sx;
    req_space = sp; ua_enable = ua; bus_rdata = bus; st_data = sd;
    expq.push_back(model(v, st, sz, a, sx, sp, ua, bus, sd, tag));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 0; req_store = 0; req_size = 0; req_addr_lo = 0; req_sext = 0;
    req_space = 0; ua_enable = 0; bus_rdata = 0; st_data = 0;
    repeat (3) @(negedge clk);
    // R1: outputs are zero while in reset
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1", "ld_result", ld_result, 32'h0);
    chk("R1", "wr_data",   wr_data,   32'h0);
    chk("R1", "flags", {28'b0, ld_commit, wr_drive, trap_req, 1'b0}, 32'h0);
    rst = 1'b0;
    // R2: idle cycle keeps outputs zero
    step(0, 0, 0, 0, 0, 1, 1, 32'hDEADBEEF, 32'h12345678, "R2");
    // R3: word load, word-handled size codes
    step(1, 0, 0, 0, 0, 1, 1, 32'h89AB_CDEF, 0, "R3");
    step(1, 0, 5, 0, 1, 1, 1, 32'h8000_0001, 0, "R3");
    step(1, 0, 3, 0, 1, 0, 1, 32'hF00D_CAFE, 0, "R3");
    // R4: byte lanes big-endian, unsigned
    for (int i = 0; i < 4; i++) step(1, 0, 1, 2'(i), 0, 1, 1, 32'h1122_3344, 0, "R4");
    for (int i = 0; i < 4; i += 2) step(1, 0, 2, 2'(i), 0, 0, 1, 32'h1122_3344, 0, "R4");
    // R5: sign fill from byte and half msb
    for (int i = 0; i < 4; i++) step(1, 0, 1, 2'(i), 1, 1, 1, 32'h80F1_7F92, 0, "R5");
    step(1, 0, 2, 0, 1, 1, 1, 32'h8001_7FFF, 0, "R5");
    step(1, 0, 2, 2, 1, 1, 1, 32'h8001_7FFF, 0, "R5");
    step(1, 0, 2, 2, 1, 1, 1, 32'h1234_9ABC, 0, "R5");
    // R6: zero fill even with msb set
    step(1, 0, 1, 0, 0, 1, 1, 32'hF0F1_F2F3, 0, "R6");
    step(1, 0, 2, 2, 0, 1, 1, 32'hF0F1_F2F3, 0, "R6");
    // R7: store replication, sext ignored
    step(1, 1, 1, 2, 1, 1, 1, 0, 32'hA5B6_C7D8, "R7");
    step(1, 1, 1, 1, 0, 1, 1, 0, 32'h0000_0081, "R7");
    step(1, 1, 2, 0, 1, 1, 1, 0, 32'h1357_9BDF, "R7");
    step(1, 1, 0, 0, 1, 1, 1, 0, 32'hFEDC_BA98, "R7");
    // R8: misalignment rules with traps enabled
    for (int i = 1; i < 4; i++) step(1, 0, 0, 2'(i), 0, 1, 1, 32'h1111_2222, 0, "R8");
    step(1, 1, 2, 1, 0, 0, 1, 0, 32'h4444_5555, "R8");
    step(1, 0, 2, 3, 0, 1, 1, 32'h6666_7777, 0, "R8");
    step(1, 1, 1, 3, 0, 1, 1, 0, 32'h0000_00EE, "R8");
    // R9: enable low, misaligned proceeds
    step(1, 0, 0, 3, 0, 1, 0, 32'hCAFE_BABE, 0, "R9");
    step(1, 1, 0, 2, 0, 0, 0, 0, 32'h0BAD_F00D, "R9");
    // R10: I/O and coprocessor space never trap
    step(1, 0, 0, 1, 0, 2, 1, 32'h2468_ACE0, 0, "R10");
    step(1, 1, 2, 3, 0, 3, 1, 0, 32'h0000_BEEF, "R10");
    step(1, 0, 0, 2, 0, 0, 1, 32'h2468_ACE0, 0, "R10");
    // R11: trapped store and load suppressed
    step(1, 1, 0, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, "R11");
    step(1, 0, 2, 1, 1, 1, 1, 32'hFFFF_FFFF, 0, "R11");
    // R12: misaligned half without trap ignores bit 0
    step(1, 0, 2, 1, 1, 1, 0, 32'h8899_1122, 0, "R12");
    step(1, 0, 2, 3, 0, 2, 1, 32'h8899_F122, 0, "R12");
    step(1, 1, 2, 3, 0, 3, 0, 0, 32'h0000_7E81, "R12");
    // back-to-back random traffic against the model
    for (int n = 0; n < 3000; n++)
      step(1'($urandom), 1'($urandom), 3'($urandom), 2'($urandom), 1'($urandom),
           2'($urandom), 1'($urandom), $urandom, $urandom, "R3/R12 random");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    compare_outputs();
    done = 1;
    finish_run();
  end

endmodule